// File: doc/BRIEF.md
# Flash Command Interpreter

This block sits behind the command port of a NOR flash device. It takes byte writes tagged with a block number and decodes them as a multi-write command language. From that it drives three outputs: the read-mode select that steers the data bus, an 8-bit status byte, and a ready flag. It covers mode switching, single-word program, block erase with a confirm write, counted buffer loads, erase and program suspend with resume, and lock control over a small bank of blocks.

Program, erase and lock operations do not touch a real array. Each one holds the interpreter busy for a fixed number of clock cycles, and the number depends on the operation kind. This lets suspend timing, resume timing and completion timing be observed cycle by cycle. A failure is decided when the operation is started: a locked target, a low program-enable input or a broken command sequence each set sticky error bits and start nothing. Reset clears the status, returns to array reads and clears every lock bit.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, or after a later reset, readMode is 0, statusByte is 80h, ready is 1, and every block is unlocked. readMode encodes 0 as array, 1 as identifier, 2 as query and 3 as status.
- R2: When idle, a write of FFh selects readMode 0, 90h selects 1, 98h selects 2 and 70h selects 3. The change is visible in the cycle after the write.
- R3: A write of 40h or 10h followed by any write starts a program of the block addressed by the second write. In the cycle after that write, ready goes to 0 and readMode to 3. Ready stays 0 for exactly PROG_CYC cycles (default 4) and then returns to 1.
- R4: Block erase is 20h followed by D0h. Erase runs ERASE_CYC cycles (default 12). Any other value in the confirm position sets status bits 5 and 4, starts nothing and selects readMode 3.
- R5: Buffered program is E8h, then a count n, then n+1 data writes, then D0h, and it runs PROG_CYC cycles. A value other than D0h in the confirm position sets status bits 5 and 4. A count above 0Fh in word mode (byteMode=0), or above 1Fh in byte mode, does the same.
- R6: 60h followed by 01h locks the addressed block. 60h followed by D0h unlocks all blocks. Each runs LOCK_CYC cycles (default 3), and the effect is in place when ready returns to 1.
- R7: A program to a locked block sets status bits 4 and 1. An erase of a locked block sets status bits 5 and 1. Neither drops ready.
- R8: With vpenOk low, a program sets status bits 3 and 4, and an erase sets bits 3 and 5. Ready stays 1.
- R9: Status bits 5, 4, 3 and 1 stay set until a 50h write clears them.
- R10: While ready is 0, every write except B0h and 70h is ignored. The status byte shows bit 7 at 0.
- R11: B0h during an erase frees the interpreter in the next cycle, with status C0h and ready 1. A program may then run. D0h resumes the erase, and the total busy time across the suspension is ERASE_CYC cycles.
- R12: B0h during a program sets status bit 2 with ready 1, and mode commands are then accepted. D0h resumes the program, and the total busy time is PROG_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Command write strobe, one cycle per write |
| wrBlk | input | BLK_W (3) | Block number of the write |
| wrData | input | 8 | Command or data byte |
| byteMode | input | 1 | 1 selects byte mode, which raises the buffer count limit |
| vpenOk | input | 1 | Program/erase enable; low blocks every operation |
| readMode | output | 2 | Read-mode select (0 array, 1 id, 2 query, 3 status) |
| statusByte | output | 8 | Status: 7 ready, 6 erase susp, 5 erase err, 4 program err, 3 enable err, 2 program susp, 1 locked, 0 zero |
| ready | output | 1 | 1 when no operation is running |

## Verification
Three properties are checked on every cycle by the assertions. Writes arriving during busy leave the command state and the mode untouched. Sticky error bits never drop without a clear command. The two suspend flags are never set together. In addition, an erase suspend always frees the engine on the next cycle, a program start at a locked block never raises busy, and the buffer word counter stays within its range.

Only the bench scenarios can show the exact busy cycle counts, including the count that must add up across a suspend and resume. The same holds for the status values after each error path, the byte-mode buffer limit, and the fact that locks are cleared by a later reset.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_READ_ID    = 8'h90;
  localparam logic [7:0] CMD_READ_QUERY = 8'h98;
  localparam logic [7:0] CMD_READ_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
  localparam logic [7:0] CMD_BUF_PROG   = 8'hE8;
  localparam logic [7:0] CMD_PROG_A     = 8'h40;
  localparam logic [7:0] CMD_PROG_B     = 8'h10;
  localparam logic [7:0] CMD_ERASE      = 8'h20;
  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_LOCK_SETUP = 8'h60;
  localparam logic [7:0] CMD_LOCK_SET   = 8'h01;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_QUERY  = 2'd2,
    RM_STATUS = 2'd3
  } readMode_e;

  typedef enum logic [1:0] {
    OP_PROG    = 2'd0,
    OP_ERASE   = 2'd1,
    OP_LOCKSET = 2'd2,
    OP_LOCKCLR = 2'd3
  } opKind_e;

  // strobes from the command decoder to the operation engine
  typedef struct packed {
    logic    start;
    opKind_e kind;
    logic    suspend;
    logic    resume;
    logic    clrStatus;
    logic    seqErr;
  } cuiStrb_t;

endpackage

// File: rtl/cui_ctrl.sv
module cui_ctrl
  import flash_cui_pkg::*;
#(
  parameter int BLK_W     = 3,
  parameter int BUF_WORDS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [BLK_W-1:0] wrBlk,
  input  logic [7:0]       wrData,
  input  logic             byteMode,
  input  logic             busy,
  output cuiStrb_t         strb,
  output logic [BLK_W-1:0] opBlk,
  output readMode_e        modeQ
);

  localparam int         LEFT_W   = $clog2(2 * BUF_WORDS + 1);
  localparam logic [7:0] WORD_LIM = 8'(BUF_WORDS - 1);
  localparam logic [7:0] BYTE_LIM = 8'(2 * BUF_WORDS - 1);

  typedef enum logic [2:0] {
    ST_CMD, ST_PROG_SU, ST_ERASE_SU, ST_LOCK_SU, ST_BUF_CNT, ST_BUF_DAT, ST_BUF_CONF
  } ctrlSt_e;

  ctrlSt_e           state, nextState;
  readMode_e         nextMode;
  logic [LEFT_W-1:0] bufLeft, nextLeft;
  logic [BLK_W-1:0]  bufBlk, nextBlk;
  logic [7:0]        cntLim;

  assign cntLim = byteMode ? BYTE_LIM : WORD_LIM;

  always_comb begin
    strb      = '0;
    opBlk     = wrBlk;
    nextState = state;
    nextMode  = modeQ;
    nextLeft  = bufLeft;
    nextBlk   = bufBlk;
    if (wrEn) begin
      if (busy) begin
        if (wrData == CMD_SUSPEND) begin
          strb.suspend = 1'b1;
          nextMode     = RM_STATUS;
        end else if (wrData == CMD_READ_STAT) begin
          nextMode = RM_STATUS;
        end
      end else begin
        unique case (state)
          ST_CMD: begin
            case (wrData)
              CMD_READ_ARRAY: nextMode = RM_ARRAY;
              CMD_READ_ID:    nextMode = RM_IDENT;
              CMD_READ_QUERY: nextMode = RM_QUERY;
              CMD_READ_STAT:  nextMode = RM_STATUS;
              CMD_CLR_STAT:   strb.clrStatus = 1'b1;
              CMD_PROG_A, CMD_PROG_B: nextState = ST_PROG_SU;
              CMD_ERASE:      nextState = ST_ERASE_SU;
              CMD_LOCK_SETUP: nextState = ST_LOCK_SU;
              CMD_BUF_PROG: begin
                nextState = ST_BUF_CNT;
                nextBlk   = wrBlk;
              end
              CMD_CONFIRM: begin
                strb.resume = 1'b1;
                nextMode    = RM_STATUS;
              end
              default: ;
            endcase
          end
          ST_PROG_SU: begin
            strb.start = 1'b1;
            strb.kind  = OP_PROG;
            nextState  = ST_CMD;
            nextMode   = RM_STATUS;
          end
          ST_ERASE_SU: begin
            if (wrData == CMD_CONFIRM) begin
              strb.start = 1'b1;
              strb.kind  = OP_ERASE;
            end else begin
              strb.seqErr = 1'b1;
            end
            nextState = ST_CMD;
            nextMode  = RM_STATUS;
          end
          ST_LOCK_SU: begin
            if (wrData == CMD_LOCK_SET) begin
              strb.start = 1'b1;
              strb.kind  = OP_LOCKSET;
            end else if (wrData == CMD_CONFIRM) begin
              strb.start = 1'b1;
              strb.kind  = OP_LOCKCLR;
            end else begin
              strb.seqErr = 1'b1;
            end
            nextState = ST_CMD;
            nextMode  = RM_STATUS;
          end
          ST_BUF_CNT: begin
            if (wrData > cntLim) begin
              strb.seqErr = 1'b1;
              nextState   = ST_CMD;
              nextMode    = RM_STATUS;
            end else begin
              nextLeft  = LEFT_W'(wrData) + 1'b1;
              nextState = ST_BUF_DAT;
            end
          end
          ST_BUF_DAT: begin
            nextLeft = bufLeft - 1'b1;
            if (bufLeft == LEFT_W'(1)) nextState = ST_BUF_CONF;
          end
          ST_BUF_CONF: begin
            opBlk = bufBlk;
            if (wrData == CMD_CONFIRM) begin
              strb.start = 1'b1;
              strb.kind  = OP_PROG;
            end else begin
              strb.seqErr = 1'b1;
            end
            nextState = ST_CMD;
            nextMode  = RM_STATUS;
          end
          default: nextState = ST_CMD;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_CMD;
      modeQ   <= RM_ARRAY;
      bufLeft <= '0;
      bufBlk  <= '0;
    end else begin
      state   <= nextState;
      modeQ   <= nextMode;
      bufLeft <= nextLeft;
      bufBlk  <= nextBlk;
    end
  end

  // R10: writes during a running operation leave decoder state and mode alone
  a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    busy && wrEn && wrData != CMD_SUSPEND && wrData != CMD_READ_STAT
    |=> $stable(state) && $stable(modeQ));

  // R5: the data countdown stays inside the legal range
  a_r5_buf_left_range: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_BUF_DAT |-> bufLeft != '0 && bufLeft <= LEFT_W'(2 * BUF_WORDS));

endmodule

// File: rtl/cui_dp.sv
module cui_dp
  import flash_cui_pkg::*;
#(
  parameter int NUM_BLK   = 8,
  parameter int BLK_W     = 3,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 12,
  parameter int LOCK_CYC  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  cuiStrb_t         strb,
  input  logic [BLK_W-1:0] opBlk,
  input  logic             vpenOk,
  output logic             busy,
  output logic [7:0]       statusByte
);

  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC)
                         ? ((ERASE_CYC > LOCK_CYC) ? ERASE_CYC : LOCK_CYC)
                         : ((PROG_CYC > LOCK_CYC) ? PROG_CYC : LOCK_CYC);
  localparam int CYC_W   = $clog2(MAX_CYC + 1);

  opKind_e              kind;
  logic [CYC_W-1:0]     cnt, eraseSave;
  logic                 eraseSusp, progSusp;
  logic                 errErase, errProg, errVpen, errLock;
  logic [NUM_BLK-1:0]   locks;
  logic [BLK_W-1:0]     lockTgt;
  logic                 startOk, eraseLike, lockHit;

  function automatic logic [CYC_W-1:0] cycFor(opKind_e k);
    case (k)
      OP_PROG:  return CYC_W'(PROG_CYC - 1);
      OP_ERASE: return CYC_W'(ERASE_CYC - 1);
      default:  return CYC_W'(LOCK_CYC - 1);
    endcase
  endfunction

  // a start is taken only when nothing conflicting is parked
  assign startOk   = strb.start && !progSusp && (!eraseSusp || strb.kind == OP_PROG);
  assign eraseLike = (strb.kind == OP_ERASE) || (strb.kind == OP_LOCKCLR);
  assign lockHit   = ((strb.kind == OP_PROG) || (strb.kind == OP_ERASE)) && locks[opBlk];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      kind      <= OP_PROG;
      cnt       <= '0;
      eraseSave <= '0;
      eraseSusp <= 1'b0;
      progSusp  <= 1'b0;
      errErase  <= 1'b0;
      errProg   <= 1'b0;
      errVpen   <= 1'b0;
      errLock   <= 1'b0;
      locks     <= '0;
      lockTgt   <= '0;
    end else begin
      if (strb.clrStatus) begin
        errErase <= 1'b0;
        errProg  <= 1'b0;
        errVpen  <= 1'b0;
        errLock  <= 1'b0;
      end
      if (strb.seqErr) begin
        errErase <= 1'b1;
        errProg  <= 1'b1;
      end
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          if (kind == OP_LOCKSET) locks[lockTgt] <= 1'b1;
          if (kind == OP_LOCKCLR) locks <= '0;
        end else if (strb.suspend && kind == OP_ERASE) begin
          eraseSave <= cnt - 1'b1;
          eraseSusp <= 1'b1;
          busy      <= 1'b0;
        end else if (strb.suspend && kind == OP_PROG && !eraseSusp) begin
          cnt      <= cnt - 1'b1;
          progSusp <= 1'b1;
          busy     <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (strb.resume && progSusp) begin
        busy     <= 1'b1;
        progSusp <= 1'b0;
      end else if (strb.resume && eraseSusp) begin
        busy      <= 1'b1;
        kind      <= OP_ERASE;
        cnt       <= eraseSave;
        eraseSusp <= 1'b0;
      end else if (startOk) begin
        if (!vpenOk) begin
          errVpen <= 1'b1;
          if (eraseLike) errErase <= 1'b1;
          else           errProg  <= 1'b1;
        end else if (lockHit) begin
          errLock <= 1'b1;
          if (eraseLike) errErase <= 1'b1;
          else           errProg  <= 1'b1;
        end else begin
          busy    <= 1'b1;
          kind    <= strb.kind;
          cnt     <= cycFor(strb.kind);
          lockTgt <= opBlk;
        end
      end
    end
  end

  assign statusByte = {~busy, eraseSusp, errErase, errProg, errVpen, progSusp, errLock, 1'b0};

  // R11/R12: only one suspension can be parked at a time
  a_r11_single_suspend: assert property (@(posedge clk) disable iff (!rstN)
    !(eraseSusp && progSusp));

  // R11: an erase suspend frees the engine on the next cycle
  a_r11_suspend_frees: assert property (@(posedge clk) disable iff (!rstN)
    busy && kind == OP_ERASE && cnt != '0 && strb.suspend |=> !busy && eraseSusp);

  // R9: error flags hold until cleared
  a_r9_prog_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errProg && !strb.clrStatus |=> errProg);
  a_r9_erase_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errErase && !strb.clrStatus |=> errErase);

  // R7: a program aimed at a locked block never raises busy
  a_r7_locked_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !progSusp && !strb.resume && strb.start && strb.kind == OP_PROG
    && locks[opBlk] |=> !busy);

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cui_pkg::*;
#(
  parameter int NUM_BLK   = 8,
  parameter int BUF_WORDS = 16,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 12,
  parameter int LOCK_CYC  = 3,
  localparam int BLK_W    = $clog2(NUM_BLK)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [BLK_W-1:0] wrBlk,
  input  logic [7:0]       wrData,
  input  logic             byteMode,
  input  logic             vpenOk,
  output logic [1:0]       readMode,
  output logic [7:0]       statusByte,
  output logic             ready
);

  cuiStrb_t         strb;
  logic [BLK_W-1:0] opBlk;
  logic             busy;
  readMode_e        modeQ;

  cui_ctrl #(.BLK_W(BLK_W), .BUF_WORDS(BUF_WORDS)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBlk(wrBlk), .wrData(wrData),
    .byteMode(byteMode), .busy(busy), .strb(strb), .opBlk(opBlk), .modeQ(modeQ)
  );

  cui_dp #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W), .PROG_CYC(PROG_CYC),
           .ERASE_CYC(ERASE_CYC), .LOCK_CYC(LOCK_CYC)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .opBlk(opBlk), .vpenOk(vpenOk),
    .busy(busy), .statusByte(statusByte)
  );

  assign readMode = busy ? RM_STATUS : modeQ;
  assign ready    = ~busy;

endmodule

// File: tb/tb_flash_cmd_if.sv
module tb_flash_cmd_if;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrBlk = '0;
  logic [7:0] wrData = '0;
  logic       byteMode = 1'b0;
  logic       vpenOk = 1'b1;
  logic [1:0] readMode;
  logic [7:0] statusByte;
  logic       ready;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_if dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBlk(wrBlk), .wrData(wrData),
    .byteMode(byteMode), .vpenOk(vpenOk), .readMode(readMode),
    .statusByte(statusByte), .ready(ready)
  );

  // {req, wr, data, blk, mode, status, ready}
  function automatic logic [26:0] v(int r, int w, int d, int b, int m, int s, int y);
    return {r[3:0], w[0], d[7:0], b[2:0], m[1:0], s[7:0], y[0]};
  endfunction

  localparam int NV = 54;
  localparam logic [26:0] VECS [NV] = '{
    // R2 mode selection
    v(2,1,'h90,0,1,'h80,1), v(2,1,'h98,0,2,'h80,1), v(2,1,'h70,0,3,'h80,1), v(2,1,'hFF,0,0,'h80,1),
    // R3 word program, four busy cycles
    v(3,1,'h40,0,0,'h80,1), v(3,1,'hAA,2,3,'h00,0), v(3,0,0,0,3,0,0), v(3,0,0,0,3,0,0),
    v(3,0,0,0,3,0,0), v(3,0,0,0,3,'h80,1),
    // R4 erase with a bad confirm
    v(4,1,'hFF,0,0,'h80,1), v(4,1,'h20,1,0,'h80,1), v(4,1,'h55,1,3,'hB0,1),
    // R9 sticky then cleared
    v(9,1,'hFF,0,0,'hB0,1), v(9,1,'h50,0,0,'h80,1),
    // R6 lock block 5
    v(6,1,'h60,5,0,'h80,1), v(6,1,'h01,5,3,0,0), v(6,0,0,0,3,0,0), v(6,0,0,0,3,0,0),
    v(6,0,0,0,3,'h80,1),
    // R7 program and erase of a locked block
    v(7,1,'h10,5,3,'h80,1), v(7,1,'h33,5,3,'h92,1), v(7,1,'h20,5,3,'h92,1),
    v(7,1,'hD0,5,3,'hB2,1), v(9,1,'h50,0,3,'h80,1),
    // R6 clear all locks
    v(6,1,'h60,0,3,'h80,1), v(6,1,'hD0,0,3,0,0), v(6,0,0,0,3,0,0), v(6,0,0,0,3,0,0),
    v(6,0,0,0,3,'h80,1),
    // R10 writes during busy are dropped (block 5 is now unlocked)
    v(10,1,'h10,5,3,'h80,1), v(10,1,'h11,5,3,0,0), v(10,1,'hFF,0,3,0,0), v(10,1,'h60,0,3,0,0),
    v(10,1,'h50,0,3,0,0), v(10,0,0,0,3,'h80,1), v(10,1,'h01,0,3,'h80,1),
    // R5 buffered program, n=1
    v(5,1,'hE8,3,3,'h80,1), v(5,1,'h01,3,3,'h80,1), v(5,1,'h11,3,3,'h80,1), v(5,1,'h22,3,3,'h80,1),
    v(5,1,'hD0,3,3,0,0), v(5,0,0,0,3,0,0), v(5,0,0,0,3,0,0), v(5,0,0,0,3,0,0),
    v(5,0,0,0,3,'h80,1),
    // R5 abort at the confirm slot
    v(5,1,'hE8,3,3,'h80,1), v(5,1,'h00,3,3,'h80,1), v(5,1,'h11,3,3,'h80,1),
    v(5,1,'h44,3,3,'hB0,1), v(9,1,'h50,0,3,'h80,1),
    // R5 count above the word-mode limit
    v(5,1,'hE8,0,3,'h80,1), v(5,1,'h10,0,3,'hB0,1), v(9,1,'h50,0,3,'h80,1)
  };

  task automatic step(input bit w, input logic [7:0] d, input logic [2:0] b);
    wrEn = w; wrData = d; wrBlk = b;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic chk(input int r, input int m, input int s, input int y);
    nChk++;
    if (readMode !== m[1:0] || statusByte !== s[7:0] || ready !== y[0]) begin
      nFail++;
      $display("FAIL R%0d: mode=%0d status=%h ready=%b, expected mode=%0d status=%h ready=%b",
               r, readMode, statusByte, ready, m, s[7:0], y[0]);
    end
  endtask

  task automatic sc(input int r, input bit w, input logic [7:0] d, input logic [2:0] b,
                    input int m, input int s, input int y);
    step(w, d, b);
    chk(r, m, s, y);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(1, 0, 'h80, 1); // R1 reset state

    for (int i = 0; i < NV; i++) begin
      logic [26:0] e;
      e = VECS[i];
      sc(int'(e[26:23]), e[22], e[21:14], e[13:11], int'(e[10:9]), int'(e[8:1]), int'(e[0]));
    end

    // R5 byte mode accepts 1Fh, 32 data writes
    byteMode = 1'b1;
    sc(5, 1, 'hE8, 1, 3, 'h80, 1);
    sc(5, 1, 'h1F, 1, 3, 'h80, 1);
    for (int i = 0; i < 32; i++) step(1'b1, 8'(i), 3'd1);
    chk(5, 3, 'h80, 1);
    sc(5, 1, 'hD0, 1, 3, 'h00, 0);
    for (int i = 0; i < 3; i++) sc(5, 0, 0, 0, 3, 'h00, 0);
    sc(5, 0, 0, 0, 3, 'h80, 1);
    sc(5, 1, 'hE8, 1, 3, 'h80, 1);
    sc(5, 1, 'h20, 1, 3, 'hB0, 1); // above the byte-mode limit
    sc(9, 1, 'h50, 0, 3, 'h80, 1);
    byteMode = 1'b0;

    // R8 program-enable low
    vpenOk = 1'b0;
    sc(8, 1, 'h40, 0, 3, 'h80, 1);
    sc(8, 1, 'h77, 0, 3, 'h98, 1);
    sc(8, 1, 'h20, 0, 3, 'h98, 1);
    sc(8, 1, 'hD0, 0, 3, 'hB8, 1);
    sc(9, 1, 'h50, 0, 3, 'h80, 1);
    vpenOk = 1'b1;

    // R11 erase suspend, nested program, resume
    sc(11, 1, 'hFF, 0, 0, 'h80, 1);
    sc(11, 1, 'h20, 1, 0, 'h80, 1);
    sc(11, 1, 'hD0, 1, 3, 'h00, 0);
    for (int i = 0; i < 3; i++) sc(11, 0, 0, 0, 3, 'h00, 0);
    sc(11, 1, 'hB0, 0, 3, 'hC0, 1);
    sc(11, 1, 'h40, 4, 3, 'hC0, 1);
    sc(11, 1, 'h55, 4, 3, 'h40, 0);
    for (int i = 0; i < 3; i++) sc(11, 0, 0, 0, 3, 'h40, 0);
    sc(11, 0, 0, 0, 3, 'hC0, 1);
    sc(11, 1, 'hD0, 0, 3, 'h00, 0);
    for (int i = 0; i < 7; i++) sc(11, 0, 0, 0, 3, 'h00, 0);
    sc(11, 0, 0, 0, 3, 'h80, 1);

    // R12 program suspend, read mode change, resume
    sc(12, 1, 'h40, 2, 3, 'h80, 1);
    sc(12, 1, 'h66, 2, 3, 'h00, 0);
    sc(12, 1, 'hB0, 0, 3, 'h84, 1);
    sc(12, 1, 'hFF, 0, 0, 'h84, 1);
    sc(12, 1, 'hD0, 0, 3, 'h00, 0);
    sc(12, 0, 0, 0, 3, 'h00, 0);
    sc(12, 0, 0, 0, 3, 'h00, 0);
    sc(12, 0, 0, 0, 3, 'h80, 1);
    sc(12, 1, 'hB0, 0, 3, 'h80, 1); // nothing running: no effect

    // R1 reset returns the mode and clears locks
    sc(1, 1, 'h60, 6, 3, 'h80, 1);
    sc(1, 1, 'h01, 6, 3, 'h00, 0);
    sc(1, 0, 0, 0, 3, 'h00, 0);
    sc(1, 0, 0, 0, 3, 'h00, 0);
    sc(1, 0, 0, 0, 3, 'h80, 1);
    sc(1, 1, 'h50, 0, 3, 'h80, 1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(1, 0, 'h80, 1);
    sc(1, 1, 'h40, 6, 0, 'h80, 1);
    sc(1, 1, 'h12, 6, 3, 'h00, 0);
    for (int i = 0; i < 3; i++) sc(1, 0, 0, 0, 3, 'h00, 0);
    sc(1, 0, 0, 0, 3, 'h80, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule